// File: doc/BRIEF.md
# Video Serial-Link Packet Framer

This block turns one pixel cycle of parallel video into one fixed-format packet for a serial link. Three or four lanes each supply a 7-bit word per pixel cycle. The framer places the lane bits into the low packet positions in a fixed order. After them it appends, in order, an audio-channel bit, a forward control-channel bit and an even-parity bit. The parity bit covers every bit that comes before it. The finished packet goes on to a scrambler and a line coder outside this block.

A mode input selects 3-lane (24-bit packet) or 4-lane (32-bit packet) operation. In 4-lane mode the last bit of the last lane is a reserved slot. A configuration bit chooses what fills that slot: the lane bit itself, or an external spare control input. The inputs are captured on any clock edge where the input-valid flag is high. The packet and its valid strobe appear one cycle later.

Top module: `vlink_packet_framer`

## Requirements
- R1: While reset is high, and on the first cycle after it, out_valid is 0 and out_packet is all zeros.
- R2: out_valid is high exactly in the cycle after a cycle in which in_valid was high. When in_valid is low, out_packet keeps its previous value.
- R3: In 3-lane mode (four_lane_mode=0), bit 7k+j of the packet is bit j of lane k, for lanes 0 to 2, which fills bits 0 to 20. Bit 21 carries aud_bit, bit 22 carries fwd_ctl_bit and bit 23 carries the parity bit.
- R4: In 3-lane mode, packet bits 31 to 24 are zero. The lane 3 word, spare_ctl and res_override have no effect on the packet.
- R5: In 4-lane mode (four_lane_mode=1), bit 7k+j of the packet is bit j of lane k, for lanes 0 to 3, which fills bits 0 to 27. Bit 28 is a pad bit fixed at 0. Bit 29 carries aud_bit, bit 30 carries fwd_ctl_bit and bit 31 carries the parity bit.
- R6: In 4-lane mode, packet bit 27 (the reserved slot, lane 3 bit 6) takes the lane bit when res_override=0 and takes spare_ctl when res_override=1.
- R7: The parity is even. The XOR of all 32 bits of a valid out_packet is 0, so the parity bit equals the XOR of all the bits below it.
- R8: The mode is taken together with the data on each capture edge. Consecutive packets captured under different modes are each formatted by their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture the current lane words and side bits |
| four_lane_mode | input | 1 | 0 = 3-lane 24-bit packet, 1 = 4-lane 32-bit packet |
| lane_bus | input | 28 | Lane k word in bits 7k+6..7k |
| aud_bit | input | 1 | Audio-channel bit |
| fwd_ctl_bit | input | 1 | Forward control-channel bit |
| spare_ctl | input | 1 | Spare control bit that can fill the reserved slot |
| res_override | input | 1 | 1 = spare_ctl replaces the reserved lane bit in 4-lane mode |
| out_valid | output | 1 | Packet valid strobe |
| out_packet | output | 32 | Framed packet, bit 0 first in slot order |

## Verification
In 4-lane mode with res_override set, the reserved-slot substitution and the parity computation happen in the same cycle. The parity must be taken over spare_ctl rather than over the lane bit it replaces. The bench provokes this with random lane words where lane 3 bit 6 and spare_ctl are drawn independently, so they often differ. It also uses a directed all-ones word with spare_ctl low. Each packet is judged on the exact slot content and on the whole-packet XOR. A mode change between back-to-back captures is also exercised, to show that each packet keeps its own width and trailer position.

// File: rtl/vlink_pkg.sv
package vlink_pkg;

    localparam int LANE_W     = 7;
    localparam int MAX_LANES  = 4;
    localparam int MIN_LANES  = 3;
    localparam int TRAIL_BITS = 3;
    localparam int PKT_W      = 32;
    localparam int BUS_W      = LANE_W * MAX_LANES;
    localparam int PKT_W_MIN  = MIN_LANES * LANE_W + TRAIL_BITS;

    typedef enum logic {
        MODE_3L = 1'b0,
        MODE_4L = 1'b1
    } lane_mode_e;

    typedef struct packed {
        logic aud;
        logic fwd;
    } side_bits_t;

endpackage

// File: rtl/vlink_lane_map.sv
module vlink_lane_map
    import vlink_pkg::*;
#(
    parameter int LW  = LANE_W,
    parameter int NL  = MAX_LANES,
    parameter int NLM = MIN_LANES
) (
    input  lane_mode_e            mode,
    input  logic [LW*NL-1:0]      lanes,
    input  logic                  res_sel,
    input  logic                  spare,
    output logic [LW*NL-1:0]      video
);
    localparam int RES_BIT = LW - 1;

    for (genvar k = 0; k < NL; k++) begin : g_lane
        if (k < NLM) begin : g_base
            assign video[k*LW +: LW] = lanes[k*LW +: LW];
        end else begin : g_extra
            logic [LW-1:0] word;
            always_comb begin
                word = (mode == MODE_4L) ? lanes[k*LW +: LW] : '0;
                if (k == NL - 1 && mode == MODE_4L && res_sel) begin
                    word[RES_BIT] = spare;
                end
            end
            assign video[k*LW +: LW] = word;
        end
    end

endmodule

// File: rtl/vlink_parity.sv
module vlink_parity #(
    parameter int W = 32
) (
    input  logic [W-1:0] data,
    output logic         par
);
    always_comb begin
        par = 1'b0;
        for (int i = 0; i < W; i++) begin
            par = par ^ data[i];
        end
    end
endmodule

// File: rtl/vlink_pkt_build.sv
module vlink_pkt_build
    import vlink_pkg::*;
#(
    parameter int LW  = LANE_W,
    parameter int NL  = MAX_LANES,
    parameter int NLM = MIN_LANES,
    parameter int PW  = PKT_W
) (
    input  lane_mode_e        mode,
    input  logic [LW*NL-1:0]  video,
    input  side_bits_t        side,
    output logic [PW-1:0]     pkt
);
    localparam int V_MIN = NLM * LW;
    localparam int W_MIN = V_MIN + TRAIL_BITS;
    localparam int V_MAX = NL * LW;

    logic [PW-1:0] body;
    logic          par;

    always_comb begin
        body = '0;
        if (mode == MODE_4L) begin
            body[V_MAX-1:0] = video;
            body[PW-3]      = side.aud;
            body[PW-2]      = side.fwd;
        end else begin
            body[V_MIN-1:0] = video[V_MIN-1:0];
            body[W_MIN-3]   = side.aud;
            body[W_MIN-2]   = side.fwd;
        end
    end

    vlink_parity #(.W(PW)) i_par (
        .data (body),
        .par  (par)
    );

    always_comb begin
        pkt = body;
        if (mode == MODE_4L) begin
            pkt[PW-1] = par;
        end else begin
            pkt[W_MIN-1] = par;
        end
    end

endmodule

// File: rtl/vlink_packet_framer.sv
module vlink_packet_framer
    import vlink_pkg::*;
#(
    parameter int LW  = LANE_W,
    parameter int NL  = MAX_LANES,
    parameter int NLM = MIN_LANES,
    parameter int PW  = PKT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 four_lane_mode,
    input  logic [LW*NL-1:0]     lane_bus,
    input  logic                 aud_bit,
    input  logic                 fwd_ctl_bit,
    input  logic                 spare_ctl,
    input  logic                 res_override,
    output logic                 out_valid,
    output logic [PW-1:0]        out_packet
);
    localparam int W_MIN   = NLM * LW + TRAIL_BITS;
    localparam int PAD_POS = NL * LW;
    localparam int RES_POS = NL * LW - 1;

    lane_mode_e        mode_in;
    lane_mode_e        mode_q;
    logic [LW*NL-1:0]  video;
    logic [PW-1:0]     pkt_next;
    side_bits_t        side;

    assign mode_in  = lane_mode_e'(four_lane_mode);
    assign side.aud = aud_bit;
    assign side.fwd = fwd_ctl_bit;

    vlink_lane_map #(.LW(LW), .NL(NL), .NLM(NLM)) i_map (
        .mode    (mode_in),
        .lanes   (lane_bus),
        .res_sel (res_override),
        .spare   (spare_ctl),
        .video   (video)
    );

    vlink_pkt_build #(.LW(LW), .NL(NL), .NLM(NLM), .PW(PW)) i_build (
        .mode  (mode_in),
        .video (video),
        .side  (side),
        .pkt   (pkt_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_packet <= '0;
            mode_q     <= MODE_3L;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_packet <= pkt_next;
                mode_q     <= mode_in;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid) else $error("valid strobe missing"); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_packet))) else $error("idle changed packet"); // R2

    AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((^out_packet) == 1'b0)) else $error("odd packet parity"); // R7

    AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && mode_q == MODE_3L) |-> (out_packet[PW-1:W_MIN] == '0)) else $error("upper bits set"); // R4

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && mode_q == MODE_4L) |-> (out_packet[PAD_POS] == 1'b0)) else $error("pad bit set"); // R5

    AST_SPARE_SLOT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && four_lane_mode && res_override) |=> (out_packet[RES_POS] == $past(spare_ctl))) else $error("reserved slot wrong"); // R6

endmodule

// File: tb/test_vlink_packet_framer.sv
module test_vlink_packet_framer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        four_lane_mode = 1'b0;
    logic [27:0] lane_bus = '0;
    logic        aud_bit = 1'b0;
    logic        fwd_ctl_bit = 1'b0;
    logic        spare_ctl = 1'b0;
    logic        res_override = 1'b0;
    logic        out_valid;
    logic [31:0] out_packet;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;
    bit finished = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          vld_q[$];
    logic [31:0] last_pkt = '0;

    always #2.5 clk = ~clk;

    vlink_packet_framer i_vlink_packet_framer (
        .clk            (clk),
        .rst            (rst),
        .in_valid       (in_valid),
        .four_lane_mode (four_lane_mode),
        .lane_bus       (lane_bus),
        .aud_bit        (aud_bit),
        .fwd_ctl_bit    (fwd_ctl_bit),
        .spare_ctl      (spare_ctl),
        .res_override   (res_override),
        .out_valid      (out_valid),
        .out_packet     (out_packet)
    );

    function automatic logic [31:0] model(bit m4, logic [27:0] lanes, bit a, bit f, bit sp, bit ro);
        logic [31:0] p;
        int nl;
        int w;
        p  = '0;
        nl = m4 ? 4 : 3;
        w  = m4 ? 32 : 24;
        for (int k = 0; k < nl; k++)
            for (int j = 0; j < 7; j++)
                p[7*k+j] = lanes[7*k+j];
        if (m4 && ro) p[27] = sp;
        p[w-3] = a;
        p[w-2] = f;
        p[w-1] = ^p;
        return p;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(bit iv, bit m4, logic [27:0] lanes, bit a, bit f, bit sp, bit ro, string tag);
        @(posedge clk);
        #1;
        in_valid       = iv;
        four_lane_mode = m4;
        lane_bus       = lanes;
        aud_bit        = a;
        fwd_ctl_bit    = f;
        spare_ctl      = sp;
        res_override   = ro;
        started        = 1'b1;
        vld_q.push_back(iv);
        if (iv) begin
            exp_q.push_back(model(m4, lanes, a, f, sp, ro));
            tag_q.push_back(tag);
        end
    endtask

    task automatic drive_rand(bit m4, bit ro, string tag, bit force_valid);
        bit iv;
        iv = force_valid ? 1'b1 : (($urandom % 4) != 0);
        drive(iv, m4, 28'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), ro, tag);
    endtask

    // monitor: pops the item captured on the previous edge
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (started && vld_q.size() >= 2) begin
                bit ev;
                ev = vld_q.pop_front();
                check(out_valid == ev, "R2", "valid strobe", 32'(out_valid), 32'(ev));
                if (ev && exp_q.size() > 0) begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_packet == e, t, "packet", out_packet, e);
                    check((^out_packet) == 1'b0, "R7", "even parity", out_packet, e);
                end else if (!ev) begin
                    check(out_packet == last_pkt, "R2", "hold while idle", out_packet, last_pkt);
                end
                last_pkt = out_packet;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check(out_valid == 1'b0, "R1", "valid in reset", 32'(out_valid), 32'd0);
        check(out_packet == '0, "R1", "packet in reset", out_packet, 32'd0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        @(posedge clk);
        #2;
        check(out_valid == 1'b0, "R1", "valid after reset", 32'(out_valid), 32'd0);
        check(out_packet == '0, "R1", "packet after reset", out_packet, 32'd0);

        // directed: all ones, both modes, spare low so slot differs
        drive(1'b1, 1'b0, 28'hFFFFFFF, 1'b1, 1'b1, 1'b1, 1'b1, "R3 R4");
        drive(1'b1, 1'b1, 28'hFFFFFFF, 1'b1, 1'b1, 1'b0, 1'b1, "R6");
        drive(1'b1, 1'b1, 28'hFFFFFFF, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
        drive(1'b0, 1'b1, 28'h0, 1'b0, 1'b0, 1'b1, 1'b1, "R2");
        drive(1'b1, 1'b0, 28'h0, 1'b0, 1'b1, 1'b1, 1'b1, "R3");
        drive(1'b0, 1'b0, 28'h5555555, 1'b1, 1'b0, 1'b0, 1'b0, "R2");

        // random 3-lane, lane 3 and override randomized (ignored)
        for (int i = 0; i < 300; i++) drive_rand(1'b0, 1'($urandom), "R3 R4", 1'b0);
        // random 4-lane, lane bit in reserved slot
        for (int i = 0; i < 300; i++) drive_rand(1'b1, 1'b0, "R5", 1'b0);
        // random 4-lane, spare fills reserved slot
        for (int i = 0; i < 300; i++) drive_rand(1'b1, 1'b1, "R6", 1'b0);
        // back-to-back mode changes
        for (int i = 0; i < 200; i++) drive_rand(1'(i), 1'($urandom), "R8", 1'b1);

        for (int i = 0; i < 4; i++) drive(1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        repeat (3) @(posedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule